// File: doc/BRIEF.md
# Push-Button Long-Hold Reset Detector

This block turns a push-button into a deliberate system-reset control. The button line is active low and rests high. The block passes it through a synchroniser and then measures how long it stays pressed. Time is counted in pulses of a slow free-running tick of about 8 kHz, which the surrounding chip supplies as a one-clock enable on the system clock. A reset request is raised only if the press lasts, without a single break, for the hold-down time chosen by a 3-bit select code. The eight settings double at each step. At 8 kHz and the default base of 2500 ticks they give roughly 0.3125 s, 0.625 s, 1.25 s, 2.5 s, 5 s, 10 s, 20 s and 40 s.

A short press, or any bounce that shows the button high for even one sampled clock, throws away everything counted so far. The next press starts again from zero. When the hold-down time completes, the block emits a request that lasts one clock and raises a "held" flag. The flag stays up until the button is let go, and no further request can fire before that. The select code is captured only while the block is idle, so moving it in the middle of a press has no effect on that press. After power-on the captured setting is code 5, which is the 10 s setting.

Top module: `lhold_rst_det`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and in the first cycle after it is released, `rst_req` and `held` are 0.
- R2: With `btn_n` held low, the first tick that reaches the block at least three clocks after the falling edge is tick 1. This allows two synchroniser flops and one state cycle. `rst_req` is 1 in the clock after tick number BASE_TICKS << `hold_sel` is consumed.
- R3: No request is produced before that tick, and `rst_req` is never 1 unless the synchronised button was low in the previous cycle.
- R4: Releasing the button before the hold-down time completes discards the press. A later press needs the full hold-down time again.
- R5: Any clock in which the synchronised button reads high clears the tick counter to zero.
- R6: `rst_req` lasts exactly one clock, and `held` is 1 in that same clock. While the button stays low after a request, no further request is produced and `held` stays 1.
- R7: `held` falls in the clock after the synchronised button is seen high. A later press can then produce a new request.
- R8: `hold_sel` is captured only while idle. A change made while a press is being timed does not alter that press's hold-down time.
- R9: Select code k (0 to 7) selects BASE_TICKS << k ticks, so each step doubles the hold-down time.
- R10: Asserting `rst_n` in the middle of a press aborts it. With the button still low after reset is released, the full hold-down time is counted afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-clock enable at the slow timing rate (about 8 kHz) |
| btn_n | input | 1 | Raw push-button, active low, asynchronous |
| hold_sel | input | SEL_W | Hold-down time select code |
| rst_req | output | 1 | One-clock reset request |
| held | output | 1 | High from the request until the button is released |

## Verification
The bench aligns each press to the tick stream and checks the tick count at which the request appears. A counter off by one tick, or a synchroniser with the wrong depth, would fire one tick early or late. A one-clock high glitch in the middle of a press, and a release two ticks short of the limit, each test restart from zero. A design that only paused its counter would fire too soon. Holding the button for three times the limit after a request tests that no second request fires and that `held` stays high. A design that re-armed on the counter wrapping would repeat the reset. Moving `hold_sel` in mid-press, and pulsing `rst_n` in mid-press, test that the frozen setting is used and that counting starts again from zero after reset.

// File: rtl/lhold_pkg.sv
package lhold_pkg;
   typedef enum logic [1:0] {
      LH_IDLE  = 2'd0,
      LH_COUNT = 2'd1,
      LH_LATCH = 2'd2
   } lh_state_e;
endpackage

// File: rtl/lhold_sync.sv
module lhold_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lhold_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RST_VAL}};
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/lhold_tmr.sv
module lhold_tmr #(
   parameter int BASE_TICKS = 2500,
   parameter int SEL_W      = 3,
   parameter int CNT_W      = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             hit,
   output logic             zero
);
   localparam int  LOG2B   = $clog2(BASE_TICKS);
   localparam bit  IS_POW2 = ((BASE_TICKS & (BASE_TICKS - 1)) == 0);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + 1'b1;

   // Limit detect: a single up-counter bit when the base is a power of two,
   // otherwise a full equality compare against the shifted base.
   if (IS_POW2) begin : g_bit_detect
      localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;
      logic [IDX_W-1:0] idx;
      assign idx = IDX_W'(LOG2B) + IDX_W'(sel);
      assign hit = en & cnt_inc[idx];
   end else begin : g_cmp_detect
      logic [CNT_W-1:0] limit;
      assign limit = CNT_W'(BASE_TICKS) << sel;
      assign hit   = en & (cnt_inc == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr || hit) cnt <= '0;
      else if (en)         cnt <= cnt_inc;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/lhold_ctl.sv
module lhold_ctl
   import lhold_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter int DEF_SEL = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             low,
   input  logic             tick,
   input  logic             hit,
   input  logic [SEL_W-1:0] hold_sel,
   output logic [SEL_W-1:0] sel_q,
   output logic             cnt_en,
   output logic             cnt_clr,
   output logic             st_count,
   output logic             rst_req,
   output logic             held
);
   lh_state_e st, st_nxt;

   always_comb begin
      st_nxt = st;
      case (st)
         LH_IDLE:  if (low) st_nxt = LH_COUNT;
         LH_COUNT: if (!low) st_nxt = LH_IDLE;
                   else if (hit) st_nxt = LH_LATCH;
         LH_LATCH: if (!low) st_nxt = LH_IDLE;
         default:  st_nxt = LH_IDLE;
      endcase
   end

   assign st_count = (st == LH_COUNT);
   assign cnt_en   = st_count & low & tick;
   assign cnt_clr  = ~st_count | ~low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= LH_IDLE;
         rst_req <= 1'b0;
         sel_q   <= SEL_W'(DEF_SEL);
      end else begin
         st      <= st_nxt;
         rst_req <= hit;
         if (st == LH_IDLE) sel_q <= hold_sel;
      end
   end

   assign held = (st == LH_LATCH);
endmodule

// File: rtl/lhold_rst_det.sv
module lhold_rst_det #(
   parameter int BASE_TICKS  = 2500,
   parameter int SEL_W       = 3,
   parameter int DEF_SEL     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             btn_n,
   input  logic [SEL_W-1:0] hold_sel,
   output logic             rst_req,
   output logic             held
);
   localparam int NSET      = 1 << SEL_W;
   localparam int MAX_TICKS = BASE_TICKS * (1 << (NSET - 1));
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel_w
      $error("lhold_rst_det: SEL_W must be 1..4");
   end
   if (DEF_SEL < 0 || DEF_SEL >= NSET) begin : g_bad_def
      $error("lhold_rst_det: DEF_SEL out of range");
   end
   if (BASE_TICKS < 2) begin : g_bad_base
      $error("lhold_rst_det: BASE_TICKS must be at least 2");
   end

   logic             btn_s;
   logic             btn_low;
   logic             hit;
   logic             cnt_zero;
   logic             cnt_en;
   logic             cnt_clr;
   logic             st_count;
   logic [SEL_W-1:0] sel_q;

   lhold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (btn_n),
      .q     (btn_s)
   );

   assign btn_low = ~btn_s;

   lhold_ctl #(.SEL_W(SEL_W), .DEF_SEL(DEF_SEL)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .low      (btn_low),
      .tick     (tick),
      .hit      (hit),
      .hold_sel (hold_sel),
      .sel_q    (sel_q),
      .cnt_en   (cnt_en),
      .cnt_clr  (cnt_clr),
      .st_count (st_count),
      .rst_req  (rst_req),
      .held     (held)
   );

   lhold_tmr #(.BASE_TICKS(BASE_TICKS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .en    (cnt_en),
      .sel   (sel_q),
      .hit   (hit),
      .zero  (cnt_zero)
   );
endmodule

// File: rtl/lhold_chk.sv
module lhold_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             held,
   input logic             btn_low,
   input logic             cnt_zero,
   input logic             st_count,
   input logic [SEL_W-1:0] sel_q
);
   a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r6_held_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> held);

   a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> !rst_req);

   a_r3_req_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(btn_low));

   a_r5_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !btn_low |=> cnt_zero);

   a_r7_release_drops_held: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !btn_low) |=> !held);

   a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      st_count |=> $stable(sel_q));
endmodule

bind lhold_rst_det lhold_chk #(.SEL_W(SEL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_req  (rst_req),
   .held     (held),
   .btn_low  (btn_low),
   .cnt_zero (cnt_zero),
   .st_count (st_count),
   .sel_q    (sel_q)
);

// File: tb/lhold_rst_det_tb_top.sv
`timescale 1ns/1ps
module lhold_rst_det_tb_top;
   localparam int BASE  = 4;
   localparam int SEL_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic             btn_n = 1'b1;
   logic [SEL_W-1:0] hold_sel = '0;
   logic             rst_req;
   logic             held;

   int n_chk = 0;
   int n_bad = 0;
   int req_cnt = 0;
   int wide_cnt = 0;
   logic prev_req = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lhold_rst_det #(.BASE_TICKS(BASE), .SEL_W(SEL_W), .DEF_SEL(5), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
      .hold_sel(hold_sel), .rst_req(rst_req), .held(held)
   );

   // tick: one clock high in every four
   logic [1:0] div = '0;
   always_ff @(posedge clk) begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
   end

   always @(negedge clk) begin
      if (rst_req) req_cnt++;
      if (rst_req && prev_req) wide_cnt++;
      prev_req = rst_req;
   end

   function automatic int lim(input int s);
      return BASE << s;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!tick);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Press aligned just after a visible tick and expect a request at exactly lim(s) ticks.
   task automatic press_expect(input int s, input string tag);
      int r0;
      wait_ticks(1);
      btn_n = 1'b0;
      r0 = req_cnt;
      wait_ticks(lim(s) - 1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0, {tag, " early"}, req_cnt - r0, 0);
      wait_ticks(1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0 + 1, {tag, " on time"}, req_cnt - r0, 1);
      chk(held == 1'b1, {tag, " held"}, held, 1);
   endtask

   task automatic release_btn(input string tag);
      btn_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(held == 1'b0, {tag, " held after release"}, held, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(rst_req == 1'b0, "R1 rst_req in reset", rst_req, 0);
      chk(held == 1'b0, "R1 held in reset", held, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rst_req == 1'b0 && held == 1'b0, "R1 after release", {rst_req, held}, 0);
      wait_ticks(2);
   endtask

   task automatic t_basic();
      hold_sel = 3'd0;
      press_expect(0, "R2 R3 sel0");
      release_btn("R7 sel0");
   endtask

   task automatic t_doubling();
      hold_sel = 3'd2; press_expect(2, "R9 sel2"); release_btn("R9 sel2");
      hold_sel = 3'd3; press_expect(3, "R9 sel3"); release_btn("R9 sel3");
      hold_sel = 3'd7; press_expect(7, "R9 sel7"); release_btn("R9 sel7");
   endtask

   task automatic t_no_repeat();
      int r1;
      hold_sel = 3'd1;
      press_expect(1, "R6 first");
      chk(wide_cnt == 0, "R6 pulse width", wide_cnt, 0);
      r1 = req_cnt;
      wait_ticks(3 * lim(1));
      chk(req_cnt == r1, "R6 no repeat", req_cnt - r1, 0);
      chk(held == 1'b1, "R6 held stays", held, 1);
      release_btn("R7 after hold");
      press_expect(1, "R7 rearm");
      release_btn("R7 rearm");
   endtask

   task automatic t_early_release();
      int r0;
      hold_sel = 3'd1;
      wait_ticks(1);
      btn_n = 1'b0;
      r0 = req_cnt;
      wait_ticks(lim(1) - 2);
      btn_n = 1'b1;
      wait_ticks(3);
      chk(req_cnt == r0, "R4 short press discarded", req_cnt - r0, 0);
      chk(held == 1'b0, "R4 held stays low", held, 0);
      press_expect(1, "R4 full time again");
      release_btn("R4");
   endtask

   task automatic t_glitch();
      int r0;
      hold_sel = 3'd1;
      wait_ticks(1);
      btn_n = 1'b0;
      wait_ticks(lim(1) - 2);
      btn_n = 1'b1;
      @(negedge clk);
      btn_n = 1'b0;
      r0 = req_cnt;
      wait_ticks(lim(1) - 1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0, "R5 glitch restarts count", req_cnt - r0, 0);
      wait_ticks(1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0 + 1, "R5 request after restart", req_cnt - r0, 1);
      release_btn("R5");
   endtask

   task automatic t_sel_change();
      int r0;
      hold_sel = 3'd1;
      wait_ticks(1);
      btn_n = 1'b0;
      r0 = req_cnt;
      wait_ticks(2);
      hold_sel = 3'd7;
      wait_ticks(lim(1) - 3);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0, "R8 early", req_cnt - r0, 0);
      wait_ticks(1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0 + 1, "R8 frozen select used", req_cnt - r0, 1);
      release_btn("R8");
   endtask

   task automatic t_async_reset();
      int r0;
      hold_sel = 3'd1;
      wait_ticks(1);
      btn_n = 1'b0;
      wait_ticks(lim(1) - 2);
      rst_n = 1'b0;
      @(negedge clk);
      chk(rst_req == 1'b0 && held == 1'b0, "R10 outputs in reset", {rst_req, held}, 0);
      wait_ticks(1);
      rst_n = 1'b1;
      r0 = req_cnt;
      wait_ticks(lim(1) - 1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0, "R10 no carry-over", req_cnt - r0, 0);
      wait_ticks(1);
      repeat (2) @(negedge clk);
      chk(req_cnt == r0 + 1, "R10 full count after reset", req_cnt - r0, 1);
      release_btn("R10");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_doubling();
      t_no_repeat();
      t_early_release();
      t_glitch();
      t_sel_change();
      t_async_reset();
      chk(wide_cnt == 0, "R6 all pulses single", wide_cnt, 0);
      report();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
   end
endmodule